// File: doc/BRIEF.md
# Memory Attribute Resolver with Store-Stream Detection

This block sits after address translation and takes the raw attributes of each access: memory type, cache policy and shareability. It reduces them to the few behaviours the first-level cache system implements. It drives four flags: whether the line may be cached, whether a write miss allocates, whether the access is shareable, and whether the first-level caches are skipped completely. Combinations that the caches cannot honour are mapped onto the nearest supported behaviour. The mapping is purely combinational, so the flags belong to the access that is on the inputs in the same cycle.

The block also watches the store stream aimed at non-shareable normal write-back memory. When a long run of whole-line stores to consecutive cache lines appears, allocating each line on a write miss would only evict useful data. The block therefore withholds write-allocate for that region while the run lasts. Anything that breaks the pattern returns the region to normal allocation from the following cycle.

Top module: `memAttrResolver`

## Requirements
- R1: Memory type `00` (strongly ordered) and `11` (reserved, handled as strongly ordered) give bypass=1, cacheable=0, write-allocate=0 and shareable=1, whatever the policy, shareability and SMP inputs are.
- R2: Memory type `01` (device) gives bypass=1, cacheable=0 and write-allocate=0. Shareable is 1 exactly when the shareability input is not `00`.
- R3: For normal memory (type `10`), bypass is 0. Cache policy `00` (non-cacheable) and `01` (write-through) both give cacheable=0 and write-allocate=0.
- R4: Cache policy `11` (write-back without allocate) resolves exactly like `10` (write-back with allocate), including how its stores take part in the run detection.
- R5: Shareability `00` is non-shareable, `01` is inner and `10`/`11` are outer. Outer resolves exactly like inner, and both give shareable=1.
- R6: Shareable normal write-back memory gives cacheable=0 and write-allocate=0 when the SMP input is 0. When the SMP input is 1 it gives cacheable=1 and write-allocate=1, and the run detection never throttles it.
- R7: All four output flags follow the attribute inputs in the same cycle, with no register in the path.
- R8: A store with full-line=1 to non-shareable normal write-back memory counts toward the run when its line address (byte address divided by 32) equals the previous counted line plus one, wrapping at the top. After the fourth consecutive counted store, write-allocate for that memory class is 0 from the next cycle on, and it stays 0 while the run continues.
- R9: A load, a store with full-line=0, or a store outside the non-shareable normal write-back class ends the run. A load has priority over a store in the same cycle. Write-allocate returns to 1 in the following cycle.
- R10: A full-line store in that class whose line does not follow the previous counted line starts a new run of length one. Four further-sequenced stores in total are then needed before throttling.
- R11: After reset the run is empty, so non-shareable normal write-back memory reports write-allocate=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memType | input | 2 | Raw memory type: 00 strongly ordered, 01 device, 10 normal, 11 reserved |
| cachePol | input | 2 | Raw cache policy: 00 non-cacheable, 01 write-through, 10 write-back allocate, 11 write-back no allocate |
| shareMode | input | 2 | Raw shareability: 00 none, 01 inner, 10/11 outer |
| smpEnable | input | 1 | Allows shareable write-back memory to be cached |
| stValid | input | 1 | A store is accepted this cycle |
| stFullLine | input | 1 | The accepted store writes a whole 32-byte line |
| stLineAddr | input | LINE_AW | Line address of the accepted store |
| ldValid | input | 1 | A load is accepted this cycle |
| effCacheable | output | 1 | Access may be cached |
| effWriteAlloc | output | 1 | A write miss allocates a line |
| effShareable | output | 1 | Access is shareable |
| l1Bypass | output | 1 | Access skips the first-level caches |

## Verification
The attribute fold is driven with a sweep of every combination of type, policy, shareability and SMP bit. This separates the folding rules from each other, for example outer from inner and write-through from non-cacheable. The store stream is tried with an unbroken ascending run, with runs cut by a load, a partial store or a store to another class, and with a run that restarts at a non-adjacent line. These patterns separate a correct threshold and restart from off-by-one counting and from plain counting of full-line stores. Further cases cover a run that crosses the wrap of the line address, a run that mixes the two write-back policies, and a load and store arriving together.

// File: rtl/memattr_pkg.sv
package memattr_pkg;

  typedef enum logic [1:0] {
    MT_STRONG = 2'b00,
    MT_DEVICE = 2'b01,
    MT_NORMAL = 2'b10,
    MT_RSVD   = 2'b11
  } memType_e;

  typedef enum logic [1:0] {
    CP_NONCACHE    = 2'b00,
    CP_WTHRU       = 2'b01,
    CP_WBACK       = 2'b10,
    CP_WBACK_NOALC = 2'b11
  } cachePol_e;

  typedef enum logic [1:0] {
    SH_NONE      = 2'b00,
    SH_INNER     = 2'b01,
    SH_OUTER     = 2'b10,
    SH_OUTER_ALT = 2'b11
  } share_e;

  // strobes from control to datapath: at most one per cycle
  typedef struct packed {
    logic runClear;
    logic runStart;
    logic runAdvance;
  } runStrobe_t;

  typedef struct packed {
    logic cacheable;
    logic writeAlloc;
    logic shareable;
    logic bypass;
  } effAttr_t;

endpackage

// File: rtl/memAttrCtrl.sv
module memAttrCtrl
  import memattr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] memType,
  input  logic [1:0] cachePol,
  input  logic [1:0] shareMode,
  input  logic       stValid,
  input  logic       stFullLine,
  input  logic       ldValid,
  input  logic       seqHit,
  input  logic       runLive,
  output runStrobe_t strb
);

  logic isNormal;
  logic isWriteBack;
  logic isNonShare;
  logic streamClass;

  assign isNormal    = (memType == MT_NORMAL);
  assign isWriteBack = (cachePol == CP_WBACK) || (cachePol == CP_WBACK_NOALC);
  assign isNonShare  = (shareMode == SH_NONE);
  assign streamClass = isNormal && isWriteBack && isNonShare;

  always_comb begin
    strb = '0;
    if (ldValid) begin
      strb.runClear = 1'b1;
    end else if (stValid) begin
      if (streamClass && stFullLine) begin
        if (runLive && seqHit) strb.runAdvance = 1'b1;
        else                   strb.runStart   = 1'b1;
      end else begin
        strb.runClear = 1'b1;
      end
    end
  end

  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.runClear, strb.runStart, strb.runAdvance}));

  // R9
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> (strb.runClear && !strb.runAdvance));

endmodule

// File: rtl/memAttrDatapath.sv
module memAttrDatapath
  import memattr_pkg::*;
#(
  parameter int LINE_AW   = 27,
  parameter int RUN_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         memType,
  input  logic [1:0]         cachePol,
  input  logic [1:0]         shareMode,
  input  logic               smpEnable,
  input  logic [LINE_AW-1:0] stLineAddr,
  input  runStrobe_t         strb,
  output logic               seqHit,
  output logic               runLive,
  output effAttr_t           eff
);

  localparam int CNT_MAX = RUN_LIMIT + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]   CNT_TOP  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0]   CNT_LIM  = CNT_W'(RUN_LIMIT);
  localparam logic [LINE_AW-1:0] LINE_ONE = LINE_AW'(1);

  logic [CNT_W-1:0]   runCnt;
  logic [LINE_AW-1:0] lastLine;
  logic               throttle;

  // run tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt   <= '0;
      lastLine <= '0;
    end else if (strb.runClear) begin
      runCnt <= '0;
    end else if (strb.runStart) begin
      runCnt   <= CNT_W'(1);
      lastLine <= stLineAddr;
    end else if (strb.runAdvance) begin
      if (runCnt < CNT_TOP) runCnt <= runCnt + CNT_W'(1);
      lastLine <= stLineAddr;
    end
  end

  assign seqHit   = (stLineAddr == (lastLine + LINE_ONE));
  assign runLive  = (runCnt != '0);
  assign throttle = (runCnt > CNT_LIM);

  // attribute folding
  logic isNormal, isWriteBack, isShared;

  assign isNormal    = (memType == MT_NORMAL);
  assign isWriteBack = (cachePol == CP_WBACK) || (cachePol == CP_WBACK_NOALC);
  assign isShared    = (shareMode != SH_NONE);

  always_comb begin
    eff = '0;
    unique case (memType)
      MT_DEVICE: begin
        eff.bypass    = 1'b1;
        eff.shareable = isShared;
      end
      MT_NORMAL: begin
        eff.shareable = isShared;
        if (isWriteBack) begin
          if (!isShared) begin
            eff.cacheable  = 1'b1;
            eff.writeAlloc = !throttle;
          end else if (smpEnable) begin
            eff.cacheable  = 1'b1;
            eff.writeAlloc = 1'b1;
          end
        end
      end
      default: begin
        eff.bypass    = 1'b1;
        eff.shareable = 1'b1;
      end
    endcase
  end

  // R1
  ordered_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memType == MT_STRONG || memType == MT_RSVD) |->
      (eff.bypass && eff.shareable && !eff.cacheable && !eff.writeAlloc));

  // R3
  wthru_nocache_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isNormal && cachePol == CP_WTHRU) |-> (!eff.cacheable && !eff.bypass));

  // R8
  run_throttle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runAdvance && runCnt == CNT_LIM) |=> throttle);

  // R9
  run_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runClear |=> !runLive);

  // R10
  run_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runStart |=> (runCnt == CNT_W'(1)));

endmodule

// File: rtl/memAttrResolver.sv
module memAttrResolver
  import memattr_pkg::*;
#(
  parameter int LINE_AW   = 27,
  parameter int RUN_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         memType,
  input  logic [1:0]         cachePol,
  input  logic [1:0]         shareMode,
  input  logic               smpEnable,
  input  logic               stValid,
  input  logic               stFullLine,
  input  logic [LINE_AW-1:0] stLineAddr,
  input  logic               ldValid,
  output logic               effCacheable,
  output logic               effWriteAlloc,
  output logic               effShareable,
  output logic               l1Bypass
);

  runStrobe_t strb;
  logic       seqHit;
  logic       runLive;
  effAttr_t   eff;

  memAttrCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .memType    (memType),
    .cachePol   (cachePol),
    .shareMode  (shareMode),
    .stValid    (stValid),
    .stFullLine (stFullLine),
    .ldValid    (ldValid),
    .seqHit     (seqHit),
    .runLive    (runLive),
    .strb       (strb)
  );

  memAttrDatapath #(
    .LINE_AW   (LINE_AW),
    .RUN_LIMIT (RUN_LIMIT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .memType    (memType),
    .cachePol   (cachePol),
    .shareMode  (shareMode),
    .smpEnable  (smpEnable),
    .stLineAddr (stLineAddr),
    .strb       (strb),
    .seqHit     (seqHit),
    .runLive    (runLive),
    .eff        (eff)
  );

  assign effCacheable  = eff.cacheable;
  assign effWriteAlloc = eff.writeAlloc;
  assign effShareable  = eff.shareable;
  assign l1Bypass      = eff.bypass;

endmodule

// File: tb/tb_memAttrResolver.sv
`timescale 1ns/1ps
module tb_memAttrResolver;

  localparam int LINE_AW = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] memType = 2'b10;
  logic [1:0] cachePol = 2'b10;
  logic [1:0] shareMode = 2'b00;
  logic smpEnable = 1'b0;
  logic stValid = 1'b0;
  logic stFullLine = 1'b0;
  logic [LINE_AW-1:0] stLineAddr = '0;
  logic ldValid = 1'b0;
  logic effCacheable, effWriteAlloc, effShareable, l1Bypass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int  runLen = 0;
  longint lastLine = 0;

  always #2 clk = ~clk;

  memAttrResolver #(.LINE_AW(LINE_AW), .RUN_LIMIT(3)) dut (
    .clk(clk), .rstN(rstN), .memType(memType), .cachePol(cachePol),
    .shareMode(shareMode), .smpEnable(smpEnable), .stValid(stValid),
    .stFullLine(stFullLine), .stLineAddr(stLineAddr), .ldValid(ldValid),
    .effCacheable(effCacheable), .effWriteAlloc(effWriteAlloc),
    .effShareable(effShareable), .l1Bypass(l1Bypass)
  );

  function automatic logic [3:0] expFlags();
    logic c, w, s, b;
    c = 0; w = 0;
    if (memType == 2'b00 || memType == 2'b11) begin
      s = 1; b = 1;
    end else begin
      s = (shareMode != 2'b00);
      b = (memType == 2'b01);
      if (memType == 2'b10 && cachePol >= 2'd2) begin
        if (!s) begin c = 1; w = (runLen <= 3); end
        else if (smpEnable) begin c = 1; w = 1; end
      end
    end
    return {c, w, s, b};
  endfunction

  function automatic string attrTag();
    if (memType != 2'b10) return (memType == 2'b01) ? "R2" : "R1";
    if (cachePol < 2'd2) return "R3";
    if (shareMode != 2'b00) return (shareMode[1]) ? "R5" : "R6";
    return (cachePol == 2'd3) ? "R4" : "R7";
  endfunction

  task automatic step(input string tag);
    logic [3:0] exp, act;
    @(negedge clk);
    #1;
    exp = expFlags();
    act = {effCacheable, effWriteAlloc, effShareable, l1Bypass};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {cache,walloc,share,bypass} actual=%b expected=%b (type=%b pol=%b sh=%b smp=%b run=%0d)",
               tag, act, exp, memType, cachePol, shareMode, smpEnable, runLen);
    end
    @(posedge clk);
    if (!rstN) begin
      runLen = 0;
    end else if (ldValid) begin
      runLen = 0;
    end else if (stValid) begin
      if (memType == 2'b10 && cachePol >= 2'd2 && shareMode == 2'b00 && stFullLine) begin
        if (runLen > 0 && longint'(stLineAddr) == ((lastLine + 1) % (longint'(1) << LINE_AW))) begin
          if (runLen < 4) runLen++;
        end else begin
          runLen = 1;
        end
        lastLine = longint'(stLineAddr);
      end else begin
        runLen = 0;
      end
    end
    #1;
  endtask

  task automatic setStream();
    memType = 2'b10; cachePol = 2'b10; shareMode = 2'b00; smpEnable = 0;
  endtask

  task automatic store(input logic [LINE_AW-1:0] line, input logic full, input string tag);
    stValid = 1; stFullLine = full; stLineAddr = line;
    step(tag);
    stValid = 0; stFullLine = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setStream();
    step("R11");
    step("R11");
    rstN = 1;
    step("R11");

    // R1 R2 R3 R4 R5 R6 R7: full sweep of the fold
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++)
          for (int m = 0; m < 2; m++) begin
            memType = 2'(t); cachePol = 2'(p); shareMode = 2'(s); smpEnable = m[0];
            step(attrTag());
          end

    // R8: unbroken run, throttles after the fourth
    setStream();
    for (int i = 0; i < 5; i++) store(LINE_AW'(100 + i), 1, "R8");
    step("R8"); step("R8");
    // R9: load releases
    ldValid = 1; step("R9"); ldValid = 0;
    step("R9");
    // R9: partial store releases
    for (int i = 0; i < 4; i++) store(LINE_AW'(200 + i), 1, "R8");
    step("R8");
    store(LINE_AW'(204), 0, "R9");
    step("R9");
    // R10: non-adjacent line restarts the run
    for (int i = 0; i < 3; i++) store(LINE_AW'(300 + i), 1, "R10");
    for (int i = 0; i < 3; i++) store(LINE_AW'(500 + i), 1, "R10");
    step("R10");
    store(LINE_AW'(503), 1, "R10");
    step("R10");
    // R4: no-allocate policy continues the same run
    cachePol = 2'b11;
    store(LINE_AW'(504), 1, "R4");
    step("R4");
    // R6 / R9: shareable SMP store ends the run and is never throttled
    shareMode = 2'b01; smpEnable = 1; cachePol = 2'b10;
    store(LINE_AW'(505), 1, "R6");
    setStream();
    step("R9");
    // R9: write-through store ends a run
    for (int i = 0; i < 4; i++) store(LINE_AW'(600 + i), 1, "R8");
    cachePol = 2'b01;
    store(LINE_AW'(604), 1, "R9");
    setStream();
    step("R9");
    // R8: wrap of the line address
    store({LINE_AW{1'b1}}, 1, "R8");
    for (int i = 0; i < 3; i++) store(LINE_AW'(i), 1, "R8");
    step("R8");
    // R9: load and store together, load wins
    stValid = 1; stFullLine = 1; stLineAddr = LINE_AW'(3); ldValid = 1;
    step("R9");
    stValid = 0; stFullLine = 0; ldValid = 0;
    step("R9");
    // R7: outputs track attribute changes with a live run
    for (int i = 0; i < 5; i++) store(LINE_AW'(800 + i), 1, "R8");
    memType = 2'b01; step("R7");
    memType = 2'b10; shareMode = 2'b10; step("R7");
    setStream(); step("R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule